// File: doc/BRIEF.md
# Cross-Timer Update Strobe Network

This block generates the update strobes for one master timer and a parameterised group of slave timers (six by default). Each timer's update pulse is the OR of two kinds of cause. The first kind is its own local causes: repetition events, counter roll-over, counter reset, burst-transfer end, three shared update-enable inputs, and a grouped software write. The second kind is the events of other timers that it has been told to follow. The counters and the transfer engine sit outside the block; their events arrive as one-cycle input pulses. When a timer's update pulse is high, the block copies that timer's preload value into its active register at the next clock edge.

Only events that come from a counter roll-over cross between timers. A timer forwards its update to followers only when a roll-over caused it, either directly or through a repetition event. Updates from transfer end, software, the enable inputs, counter reset, or a followed timer stay on the timer that received them. Forwarding is therefore never transitive. A forwarded update reaches every follower in the same clock cycle as the source event. Configuration is held in registers loaded through a single write port.

Top module: `upd_prop_net`

## Requirements
- R1: Master local causes work as follows. Control bit 0 of address 0 (repetition enable) makes a repetition-after-roll-over or a repetition-after-counter-reset produce a master update. Address 0 bits [2:1] set the transfer mode. Mode 01 updates on a transfer-end pulse. Mode 10 arms on a transfer-end pulse, then updates on the next master roll-over, with no update on the transfer end itself.
- R2: A slave whose follow-master bit (bit 2 of its address) is set updates in the same cycle as every master update that comes from a repetition-after-roll-over or from the mode-10 roll-over.
- R3: Master updates from transfer-end mode 01, from repetition-after-counter-reset, or from the master software bit never reach a follower.
- R4: Slave k (address k+1) forwards its update to every slave whose follow mask (bits [7+N-1:7]) has bit k set, in the same cycle. Forwarding applies only to three causes: a repetition-after-roll-over with repetition enable (bit 0) set, a roll-over with reset-update enable (bit 1) set, and the roll-over after a transfer end with gate code 0010 (bits [6:3]). A slave's own mask bit has no effect.
- R5: The following slave causes update only that slave: counter reset (with bit 1), repetition-after-counter-reset (with bit 0), transfer end with gate code 0001, and update-enable input 0, 1 or 2 with gate codes 0011, 0100, 0101.
- R6: An update a slave takes because it follows the master or another slave is never forwarded: if C follows B and B follows A, an event on A updates C only when C's mask names A.
- R7: A write to address all-ones raises, in that same cycle, the update of the master for data bit 0 and of slave k for bit k+1. These updates are not forwarded.
- R8: Each update pulse lasts only the cycles its cause is present. The cycle after a timer's update, its active value equals the preload input sampled in the update cycle. Without an update, the active value holds.
- R9: After reset all configuration, arm state and active values are zero. While no event input and no write is present, no update output is high.
- R10: Configuration writes take effect from the next cycle. Writes to addresses above N other than all-ones change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address |
| cfg_wdata_i | input | 7+N | Configuration write data |
| m_roll_i | input | 1 | Master counter roll-over pulse |
| m_rep_roll_i | input | 1 | Master repetition event after roll-over |
| m_rep_rst_i | input | 1 | Master repetition event after counter reset |
| m_dma_end_i | input | 1 | Master burst-transfer end pulse |
| s_roll_i | input | N | Slave counter roll-over pulses |
| s_rep_roll_i | input | N | Slave repetition after roll-over |
| s_rep_rst_i | input | N | Slave repetition after counter reset |
| s_cnt_rst_i | input | N | Slave counter reset pulses |
| s_dma_end_i | input | N | Slave burst-transfer end pulses |
| upd_en_i | input | 3 | Shared update-enable inputs |
| m_pre_i | input | DW | Master preload value |
| s_pre_i | input | N x DW | Slave preload values |
| m_upd_o | output | 1 | Master update pulse |
| s_upd_o | output | N | Slave update pulses |
| m_act_o | output | DW | Master active value |
| s_act_o | output | N x DW | Slave active values |

## Verification
The assertions watch, on every cycle, properties that hold whatever the configuration: a master repetition-after-roll-over update reaching every master follower, a grouped software write raising each selected strobe, the load and hold of every active register, and the silence of all strobes when nothing happens. The rules that depend on configuration are shown only by the bench's scenarios, which compare every strobe with a reference model. These rules cover non-transitive chains, the local-only causes, the gate codes, the arming of the roll-after-transfer mode, and ignored mask and address bits.

// File: rtl/upd_prop_pkg.sv
package upd_prop_pkg;

    // master transfer-end handling
    localparam logic [1:0] MDMA_END  = 2'b01;
    localparam logic [1:0] MDMA_ROLL = 2'b10;

    // slave gating codes
    localparam logic [3:0] GATE_DMA      = 4'b0001;
    localparam logic [3:0] GATE_ROLL_DMA = 4'b0010;
    localparam logic [3:0] GATE_EN0      = 4'b0011;
    localparam logic [3:0] GATE_EN1      = 4'b0100;
    localparam logic [3:0] GATE_EN2      = 4'b0101;

    // bit position of the follow mask inside a slave word
    localparam int MASK_LSB = 7;

    typedef struct packed {
        logic [1:0] dma_mode;
        logic       rep_en;
    } mcfg_t;

    typedef struct packed {
        logic [3:0] gate;
        logic       fol_m;
        logic       rst_en;
        logic       rep_en;
    } scfg_t;

endpackage

// File: rtl/upd_cfg_regs.sv
module upd_cfg_regs
    import upd_prop_pkg::*;
#(
    parameter int N  = 6,
    parameter int AW = 4,
    parameter int WW = MASK_LSB + N
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [WW-1:0]         wdata_i,
    output mcfg_t                 m_cfg_o,
    output scfg_t [N-1:0]         s_cfg_o,
    output logic  [N-1:0][N-1:0]  s_mask_o,
    output logic  [N:0]           sw_o
);

    localparam logic [AW-1:0] SW_ADDR = '1;

    typedef struct packed {
        mcfg_t                m;
        scfg_t [N-1:0]        s;
        logic  [N-1:0][N-1:0] mask;
    } cfg_state_t;

    cfg_state_t q, d;

    always_comb begin
        d    = q;
        sw_o = '0;
        if (we_i) begin
            if (addr_i == '0) begin
                d.m.rep_en   = wdata_i[0];
                d.m.dma_mode = wdata_i[2:1];
            end
            for (int k = 0; k < N; k++) begin
                if (addr_i == AW'(k + 1)) begin
                    d.s[k].rep_en = wdata_i[0];
                    d.s[k].rst_en = wdata_i[1];
                    d.s[k].fol_m  = wdata_i[2];
                    d.s[k].gate   = wdata_i[6:3];
                    d.mask[k]     = wdata_i[MASK_LSB +: N] & ~(N'(1) << k);
                end
            end
            if (addr_i == SW_ADDR) begin
                sw_o = wdata_i[N:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign m_cfg_o  = q.m;
    assign s_cfg_o  = q.s;
    assign s_mask_o = q.mask;

endmodule

// File: rtl/upd_src_master.sv
module upd_src_master
    import upd_prop_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  mcfg_t cfg_i,
    input  logic  roll_i,
    input  logic  rep_roll_i,
    input  logic  rep_rst_i,
    input  logic  dma_end_i,
    input  logic  sw_i,
    output logic  loc_o,
    output logic  fwd_o
);

    typedef struct packed {
        logic armed;
    } mst_state_t;

    mst_state_t q, d;
    logic roll_mode;
    logic fire;

    always_comb begin
        d         = q;
        roll_mode = (cfg_i.dma_mode == MDMA_ROLL);
        fire      = roll_mode & q.armed & roll_i;
        d.armed   = roll_mode ? ((q.armed & ~roll_i) | dma_end_i) : 1'b0;
        fwd_o     = (cfg_i.rep_en & rep_roll_i) | fire;
        loc_o     = (cfg_i.rep_en & rep_rst_i)
                  | ((cfg_i.dma_mode == MDMA_END) & dma_end_i)
                  | sw_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/upd_src_slave.sv
module upd_src_slave
    import upd_prop_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  scfg_t      cfg_i,
    input  logic       roll_i,
    input  logic       rep_roll_i,
    input  logic       rep_rst_i,
    input  logic       cnt_rst_i,
    input  logic       dma_end_i,
    input  logic [2:0] upd_en_i,
    input  logic       sw_i,
    output logic       loc_o,
    output logic       fwd_o
);

    typedef struct packed {
        logic armed;
    } slv_state_t;

    slv_state_t q, d;
    logic roll_mode;
    logic fire;
    logic gated;

    always_comb begin
        d         = q;
        roll_mode = (cfg_i.gate == GATE_ROLL_DMA);
        fire      = roll_mode & q.armed & roll_i;
        d.armed   = roll_mode ? ((q.armed & ~roll_i) | dma_end_i) : 1'b0;
        unique case (cfg_i.gate)
            GATE_DMA: gated = dma_end_i;
            GATE_EN0: gated = upd_en_i[0];
            GATE_EN1: gated = upd_en_i[1];
            GATE_EN2: gated = upd_en_i[2];
            default:  gated = 1'b0;
        endcase
        fwd_o = (cfg_i.rep_en & rep_roll_i)
              | (cfg_i.rst_en & roll_i)
              | fire;
        loc_o = (cfg_i.rep_en & rep_rst_i)
              | (cfg_i.rst_en & cnt_rst_i)
              | gated
              | sw_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/upd_prop_net.sv
module upd_prop_net
    import upd_prop_pkg::*;
#(
    parameter  int N  = 6,
    parameter  int DW = 16,
    parameter  int AW = 4,
    localparam int CW = MASK_LSB + N
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_we_i,
    input  logic [AW-1:0]         cfg_addr_i,
    input  logic [CW-1:0]         cfg_wdata_i,
    input  logic                  m_roll_i,
    input  logic                  m_rep_roll_i,
    input  logic                  m_rep_rst_i,
    input  logic                  m_dma_end_i,
    input  logic [N-1:0]          s_roll_i,
    input  logic [N-1:0]          s_rep_roll_i,
    input  logic [N-1:0]          s_rep_rst_i,
    input  logic [N-1:0]          s_cnt_rst_i,
    input  logic [N-1:0]          s_dma_end_i,
    input  logic [2:0]            upd_en_i,
    input  logic [DW-1:0]         m_pre_i,
    input  logic [N-1:0][DW-1:0]  s_pre_i,
    output logic                  m_upd_o,
    output logic [N-1:0]          s_upd_o,
    output logic [DW-1:0]         m_act_o,
    output logic [N-1:0][DW-1:0]  s_act_o
);

    mcfg_t                m_cfg;
    scfg_t [N-1:0]        s_cfg;
    logic  [N-1:0][N-1:0] s_mask;
    logic  [N:0]          sw;
    logic                 m_loc, m_fwd;
    logic  [N-1:0]        s_loc, s_fwd;
    logic  [N-1:0]        fol_m_vec;

    upd_cfg_regs #(.N(N), .AW(AW), .WW(CW)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .m_cfg_o  (m_cfg),
        .s_cfg_o  (s_cfg),
        .s_mask_o (s_mask),
        .sw_o     (sw)
    );

    upd_src_master u_mst (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (m_cfg),
        .roll_i     (m_roll_i),
        .rep_roll_i (m_rep_roll_i),
        .rep_rst_i  (m_rep_rst_i),
        .dma_end_i  (m_dma_end_i),
        .sw_i       (sw[0]),
        .loc_o      (m_loc),
        .fwd_o      (m_fwd)
    );

    for (genvar k = 0; k < N; k++) begin : g_slv
        upd_src_slave u_slv (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cfg_i      (s_cfg[k]),
            .roll_i     (s_roll_i[k]),
            .rep_roll_i (s_rep_roll_i[k]),
            .rep_rst_i  (s_rep_rst_i[k]),
            .cnt_rst_i  (s_cnt_rst_i[k]),
            .dma_end_i  (s_dma_end_i[k]),
            .upd_en_i   (upd_en_i),
            .sw_i       (sw[k+1]),
            .loc_o      (s_loc[k]),
            .fwd_o      (s_fwd[k])
        );
        assign fol_m_vec[k] = s_cfg[k].fol_m;
    end

    typedef struct packed {
        logic [DW-1:0]        m_act;
        logic [N-1:0][DW-1:0] s_act;
    } act_state_t;

    act_state_t q, d;

    // followed events are taken only from the sources' own forwardable causes
    always_comb begin
        d       = q;
        m_upd_o = m_loc | m_fwd;
        for (int k = 0; k < N; k++) begin
            s_upd_o[k] = s_loc[k] | s_fwd[k]
                       | (fol_m_vec[k] & m_fwd)
                       | (|(s_mask[k] & s_fwd));
        end
        if (m_upd_o) d.m_act = m_pre_i;
        for (int k = 0; k < N; k++) begin
            if (s_upd_o[k]) d.s_act[k] = s_pre_i[k];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign m_act_o = q.m_act;
    assign s_act_o = q.s_act;

endmodule

// File: rtl/upd_prop_chk.sv
module upd_prop_chk #(
    parameter int N  = 6,
    parameter int DW = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 m_upd,
    input logic [N-1:0]         s_upd,
    input logic [DW-1:0]        m_act,
    input logic [DW-1:0]        m_pre,
    input logic [N-1:0][DW-1:0] s_act,
    input logic [N-1:0][DW-1:0] s_pre,
    input logic                 m_rep_en,
    input logic                 m_rep_roll,
    input logic [N-1:0]         fol_m,
    input logic                 sw_we,
    input logic [N:0]           sw_bits,
    input logic                 any_evt
);

    AST_MSTR_REP_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_rep_en && m_rep_roll) |-> m_upd); // R1

    AST_SW_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_we |-> (({s_upd, m_upd} & sw_bits) == sw_bits)); // R7

    AST_MACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_upd |=> (m_act == $past(m_pre))); // R8

    AST_MACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !m_upd |=> $stable(m_act)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_evt |-> (!m_upd && (s_upd == '0))); // R9

    for (genvar k = 0; k < N; k++) begin : g_k
        AST_FOLLOW_MSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (m_rep_en && m_rep_roll && fol_m[k]) |-> s_upd[k]); // R2

        AST_SACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            s_upd[k] |=> (s_act[k] == $past(s_pre[k]))); // R8

        AST_SACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !s_upd[k] |=> $stable(s_act[k])); // R8
    end

endmodule

bind upd_prop_net upd_prop_chk #(.N(N), .DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .m_upd      (m_upd_o),
    .s_upd      (s_upd_o),
    .m_act      (m_act_o),
    .m_pre      (m_pre_i),
    .s_act      (s_act_o),
    .s_pre      (s_pre_i),
    .m_rep_en   (m_cfg.rep_en),
    .m_rep_roll (m_rep_roll_i),
    .fol_m      (fol_m_vec),
    .sw_we      (cfg_we_i && (cfg_addr_i == '1)),
    .sw_bits    (cfg_wdata_i[N:0]),
    .any_evt    (cfg_we_i | m_roll_i | m_rep_roll_i | m_rep_rst_i | m_dma_end_i
                 | (|s_roll_i) | (|s_rep_roll_i) | (|s_rep_rst_i)
                 | (|s_cnt_rst_i) | (|s_dma_end_i) | (|upd_en_i))
);

// File: tb/tb_upd_prop_net.sv
module tb_upd_prop_net;

    localparam int N  = 6;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int CW = 7 + N;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 cfg_we;
    logic [AW-1:0]        cfg_addr;
    logic [CW-1:0]        cfg_wdata;
    logic                 m_roll, m_rep_roll, m_rep_rst, m_dma;
    logic [N-1:0]         s_roll, s_rep_roll, s_rep_rst, s_cnt_rst, s_dma;
    logic [2:0]           upd_en;
    logic [DW-1:0]        m_pre;
    logic [N-1:0][DW-1:0] s_pre;
    logic                 m_upd;
    logic [N-1:0]         s_upd;
    logic [DW-1:0]        m_act;
    logic [N-1:0][DW-1:0] s_act;

    always #4 clk = ~clk;

    upd_prop_net #(.N(N), .DW(DW), .AW(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .m_roll_i(m_roll), .m_rep_roll_i(m_rep_roll), .m_rep_rst_i(m_rep_rst),
        .m_dma_end_i(m_dma),
        .s_roll_i(s_roll), .s_rep_roll_i(s_rep_roll), .s_rep_rst_i(s_rep_rst),
        .s_cnt_rst_i(s_cnt_rst), .s_dma_end_i(s_dma), .upd_en_i(upd_en),
        .m_pre_i(m_pre), .s_pre_i(s_pre),
        .m_upd_o(m_upd), .s_upd_o(s_upd), .m_act_o(m_act), .s_act_o(s_act)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // reference model state
    logic           mrep, mpend;
    logic [1:0]     mdma;
    logic           srep [N];
    logic           srst [N];
    logic           sfm  [N];
    logic           spend[N];
    logic [3:0]     sgate[N];
    logic [N-1:0]   smask[N];
    logic [DW-1:0]  e_mact;
    logic [DW-1:0]  e_sact[N];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        m_roll = 0; m_rep_roll = 0; m_rep_rst = 0; m_dma = 0;
        s_roll = '0; s_rep_roll = '0; s_rep_rst = '0; s_cnt_rst = '0; s_dma = '0;
        upd_en = '0;
    endtask

    task automatic model_reset();
        mrep = 0; mpend = 0; mdma = '0; e_mact = '0;
        for (int k = 0; k < N; k++) begin
            srep[k] = 0; srst[k] = 0; sfm[k] = 0; spend[k] = 0;
            sgate[k] = '0; smask[k] = '0; e_sact[k] = '0;
        end
    endtask

    // inputs are set after a falling edge; check, advance model, wait next falling edge
    task automatic step(input string tag);
        logic [N:0]   sw, exp, got;
        logic         mfwd, mloc;
        logic [N-1:0] sfwd, sloc;
        logic         fire;
        #1;
        sw   = (cfg_we && cfg_addr == '1) ? cfg_wdata[N:0] : '0;
        mfwd = (mrep && m_rep_roll) || (m_roll && mpend && mdma == 2'b10);
        mloc = (mrep && m_rep_rst) || (mdma == 2'b01 && m_dma) || sw[0];
        for (int k = 0; k < N; k++) begin
            fire    = s_roll[k] && spend[k] && sgate[k] == 4'd2;
            sfwd[k] = (srep[k] && s_rep_roll[k]) || (srst[k] && s_roll[k]) || fire;
            sloc[k] = (srep[k] && s_rep_rst[k]) || (srst[k] && s_cnt_rst[k])
                    || (sgate[k] == 4'd1 && s_dma[k]) || (sgate[k] == 4'd3 && upd_en[0])
                    || (sgate[k] == 4'd4 && upd_en[1]) || (sgate[k] == 4'd5 && upd_en[2])
                    || sw[k+1];
        end
        exp[0] = mfwd | mloc;
        for (int k = 0; k < N; k++) begin
            exp[k+1] = sloc[k] | sfwd[k] | (sfm[k] & mfwd)
                     | (|(smask[k] & sfwd & ~(N'(1) << k)));
        end
        got = {s_upd, m_upd};
        chk({tag, " update strobes"}, 32'(got), 32'(exp));
        chk({tag, " R8 master active"}, 32'(m_act), 32'(e_mact));
        for (int k = 0; k < N; k++) chk({tag, " R8 slave active"}, 32'(s_act[k]), 32'(e_sact[k]));
        // advance model
        if (exp[0]) e_mact = m_pre;
        for (int k = 0; k < N; k++) if (exp[k+1]) e_sact[k] = s_pre[k];
        mpend = (mdma == 2'b10) ? ((mpend & ~m_roll) | m_dma) : 1'b0;
        for (int k = 0; k < N; k++)
            spend[k] = (sgate[k] == 4'd2) ? ((spend[k] & ~s_roll[k]) | s_dma[k]) : 1'b0;
        if (cfg_we) begin
            if (cfg_addr == '0) begin
                mrep = cfg_wdata[0]; mdma = cfg_wdata[2:1];
            end
            for (int k = 0; k < N; k++) begin
                if (cfg_addr == AW'(k + 1)) begin
                    srep[k] = cfg_wdata[0]; srst[k] = cfg_wdata[1]; sfm[k] = cfg_wdata[2];
                    sgate[k] = cfg_wdata[6:3]; smask[k] = cfg_wdata[7 +: N];
                end
            end
        end
        @(negedge clk);
        clear_inputs();
        m_pre = DW'($urandom);
        for (int k = 0; k < N; k++) s_pre[k] = DW'($urandom);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] dat, input string tag);
        cfg_we = 1; cfg_addr = a; cfg_wdata = dat;
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0;
        clear_inputs();
        m_pre = 16'h1111;
        for (int k = 0; k < N; k++) s_pre[k] = DW'(16'h2000 + k);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        step("R9 idle after reset");

        // master follow and master causes
        wr(4'd1, 13'h0004, "R10 slave0 follows master");
        wr(4'd0, 13'h0003, "R10 master rep on, mode 01");
        m_rep_roll = 1; step("R2 rep-after-roll forwarded");
        m_rep_rst = 1;  step("R3 rep-after-reset local");
        m_dma = 1;      step("R3 mode 01 transfer end local");
        wr(4'hF, 13'h0001, "R7 master software only");
        step("R8 one-cycle pulse then quiet");
        wr(4'd0, 13'h0005, "R10 master mode 10");
        m_dma = 1;  step("R1 arm, no update on transfer end");
        m_roll = 1; step("R2 roll after transfer end forwarded");
        m_roll = 1; step("R1 arm consumed");

        // slave chain: s1 follows s0, s2 follows s1
        wr(4'd1, 13'h0002, "R10 slave0 reset-update");
        wr(4'd2, 13'(1 << 7), "R10 slave1 mask s0");
        wr(4'd3, 13'(1 << 8), "R10 slave2 mask s1");
        s_roll[0] = 1;    step("R6 chain not transitive");
        s_cnt_rst[0] = 1; step("R5 counter reset local");
        wr(4'd1, 13'h0003, "R10 slave0 rep and reset");
        s_rep_roll[0] = 1; step("R4 rep-after-roll forwarded");
        s_rep_rst[0] = 1;  step("R5 rep-after-reset local");

        // gate codes on slave3, slave4 follows slave3
        wr(4'd4, 13'(3 << 3), "R10 slave3 gate 0011");
        wr(4'd5, 13'(1 << 10), "R10 slave4 mask s3");
        upd_en = 3'b001; step("R5 enable input local");
        upd_en = 3'b110; step("R5 other enable inputs ignored");
        wr(4'd4, 13'(2 << 3), "R10 slave3 gate 0010");
        s_dma[3] = 1;  step("R5 arm only");
        s_roll[3] = 1; step("R4 roll after transfer end forwarded");

        // self mask bit has no effect
        wr(4'd6, 13'((1 << 12) | (1 << 7)), "R10 slave5 mask self and s0");
        s_roll[5] = 1; step("R4 self mask ignored");
        s_roll[0] = 1; step("R4 follower of s0");
        wr(4'hF, 13'h007E, "R7 all slaves software, not forwarded");
        wr(4'd9, '1, "R10 unmapped address");
        s_roll[0] = 1; step("R10 config unchanged after unmapped write");

        // constrained random mix
        for (int it = 0; it < 3000; it++) begin
            m_roll     = ($urandom_range(0, 99) < 12);
            m_rep_roll = ($urandom_range(0, 99) < 10);
            m_rep_rst  = ($urandom_range(0, 99) < 8);
            m_dma      = ($urandom_range(0, 99) < 8);
            for (int k = 0; k < N; k++) begin
                s_roll[k]     = ($urandom_range(0, 99) < 12);
                s_rep_roll[k] = ($urandom_range(0, 99) < 8);
                s_rep_rst[k]  = ($urandom_range(0, 99) < 6);
                s_cnt_rst[k]  = ($urandom_range(0, 99) < 6);
                s_dma[k]      = ($urandom_range(0, 99) < 8);
            end
            upd_en = 3'($urandom_range(0, 7)) & {3{($urandom_range(0, 99) < 20)}};
            if ($urandom_range(0, 99) < 10) begin
                cfg_we    = 1;
                cfg_addr  = AW'($urandom_range(0, 15));
                cfg_wdata = CW'($urandom);
            end
            step("R4/R5/R6 random mix");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule